// File: doc/BRIEF.md
# Quarter-Scatter Register Writer

This block takes one full-width memory beat per clock cycle and spreads it over a group of four consecutive registers in a wide register file. The beat is cut into four equal blocks. Block k goes to register base+k of the group. A two-bit variant selector chooses which quarter of every target register receives its block. The other three quarters of those registers keep their contents.

Software issues the four variants, one per cycle, each with the next row-major line of a source matrix. After the fourth load, the register group holds a four-row tile with one matrix row per register, built up quarter by quarter.

The block drives a registered per-register, per-quarter write strobe vector that reports each write. It also flags requests whose base register is misaligned or out of range. A registered read port returns any register.

Top module: `lsw_scatter_writer`

## Requirements
- R1: On an accepted request, beat bits [k*BLK_W +: BLK_W] are written into register base+k for k = 0..3, where BLK_W = REG_W/4.
- R2: An accepted request leaves unchanged the three unselected quarters of each target register and every register outside the group.
- R3: Selector value q (0..3) writes bits [q*BLK_W +: BLK_W] of each target register.
- R4: After four accepted requests to the same base with q = 0, 1, 2, 3 carrying beats d0..d3, register base+k equals the concatenation, from high to low, of block k of d3, d2, d1 and d0.
- R5: A request is rejected when base is not a multiple of 4 or base > NUM_REGS-4. In the cycle after a rejected request, err is 1, wr_strb is all zero and no register changes. Otherwise err is 0.
- R6: In the cycle after an accepted request, wr_strb has exactly bits (base+k)*4+q set, for k = 0..3, and no other bits.
- R7: A request exists only when ld_valid and ld_we are both 1. In any other case nothing is written, and in the next cycle err is 0 and wr_strb is zero.
- R8: Requests on consecutive cycles are each applied, one per cycle, with no lost writes.
- R9: rd_data shows the register selected by rd_idx at the previous clock edge, with the content as it was before any write at that same edge. A write at one edge is therefore seen by a read that samples at the next edge.
- R10: While rst is 1, err and wr_strb are cleared at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Beat valid |
| ld_we | input | 1 | Write enable for the beat |
| ld_base | input | IDX_W | First register of the destination group |
| ld_qsel | input | 2 | Quarter variant selector |
| ld_data | input | REG_W | Memory beat, four blocks of BLK_W bits |
| rd_idx | input | IDX_W | Read register index |
| rd_data | output | REG_W | Registered read data |
| wr_strb | output | NUM_REGS*4 | Registered strobe of the quarters written at the last edge, bit r*4+q |
| err | output | 1 | Registered flag for a rejected request |

## Verification
The bench builds the block with NUM_REGS = 16 and REG_W = 32, which gives 8-bit quarters and four register groups. This makes a full sweep practical: every base index 0..15, all four selectors, and write enable both on and off. A full readback of all registers follows every request and is compared against an arithmetic model. The small file also reaches the top-of-range base 12, the rejected bases 13..15, misaligned bases, back-to-back loads and a read that collides with a write in the same cycle.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  // registers per scatter group, fixed by the four quarter variants
  localparam int unsigned LSW_GROUP = 4;

  typedef enum logic [1:0] {
    QTR_0 = 2'd0,
    QTR_1 = 2'd1,
    QTR_2 = 2'd2,
    QTR_3 = 2'd3
  } lsw_qtr_e;

  function automatic logic [LSW_GROUP-1:0] lsw_qmask(input lsw_qtr_e q);
    logic [LSW_GROUP-1:0] m;
    m = '0;
    m[q] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/lsw_decode.sv
module lsw_decode #(
  parameter int unsigned NUM_REGS = 48,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS),
  parameter int unsigned ROW_W    = IDX_W - 2
) (
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [IDX_W-1:0] base,
  input  logic [1:0]       qsel,
  output logic             accept,
  output logic             reject,
  output logic [ROW_W-1:0] row,
  output logic [3:0]       qmask
);
  import lsw_pkg::*;

  logic req;
  logic aligned;
  logic in_range;

  always_comb begin
    req      = req_valid & req_we;
    aligned  = (base[1:0] == 2'b00);
    in_range = (int'(base) <= int'(NUM_REGS - LSW_GROUP));
    accept   = req & aligned & in_range;
    reject   = req & ~(aligned & in_range);
    row      = base[IDX_W-1:2];
    qmask    = lsw_qmask(lsw_qtr_e'(qsel));
  end

endmodule

// File: rtl/lsw_bank.sv
module lsw_bank #(
  parameter int unsigned ROWS  = 12,
  parameter int unsigned ROW_W = 4,
  parameter int unsigned REG_W = 256,
  parameter int unsigned NQ    = 4,
  parameter int unsigned BLK_W = REG_W / NQ
) (
  input  logic             clk,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [NQ-1:0]    wr_qmask,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic [ROW_W-1:0] rd_row,
  output logic [REG_W-1:0] rd_word
);

  logic [REG_W-1:0] mem [ROWS];

  // quarter-enable write, read-first registered read
  always_ff @(posedge clk) begin
    for (int q = 0; q < int'(NQ); q++) begin
      if (wr_qmask[q]) mem[wr_row][q*BLK_W +: BLK_W] <= wr_blk;
    end
    rd_word <= mem[rd_row];
  end

endmodule

// File: rtl/lsw_scatter_writer.sv
module lsw_scatter_writer #(
  parameter int unsigned NUM_REGS = 48,
  parameter int unsigned REG_W    = 256,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ld_valid,
  input  logic                         ld_we,
  input  logic [IDX_W-1:0]             ld_base,
  input  logic [1:0]                   ld_qsel,
  input  logic [REG_W-1:0]             ld_data,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [REG_W-1:0]             rd_data,
  output logic [NUM_REGS*lsw_pkg::LSW_GROUP-1:0] wr_strb,
  output logic                         err
);
  import lsw_pkg::*;

  localparam int unsigned GRP   = LSW_GROUP;
  localparam int unsigned BLK_W = REG_W / GRP;
  localparam int unsigned ROWS  = NUM_REGS / GRP;
  localparam int unsigned ROW_W = IDX_W - 2;
  localparam int unsigned SW    = NUM_REGS * GRP;

  logic             accept;
  logic             reject;
  logic [ROW_W-1:0] row;
  logic [GRP-1:0]   qmask;
  logic [GRP-1:0]   wr_qmask;
  logic [REG_W-1:0] bank_rd [GRP];
  logic [1:0]       rd_bank_q;
  logic [SW-1:0]    strb_d;

  lsw_decode #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .ROW_W    (ROW_W)
  ) dec_i (
    .req_valid (ld_valid),
    .req_we    (ld_we),
    .base      (ld_base),
    .qsel      (ld_qsel),
    .accept    (accept),
    .reject    (reject),
    .row       (row),
    .qmask     (qmask)
  );

  assign wr_qmask = accept ? qmask : '0;

  // bank k holds registers 4*j+k, so an aligned group hits each bank once
  for (genvar k = 0; k < int'(GRP); k++) begin : g_bank
    lsw_bank #(
      .ROWS  (ROWS),
      .ROW_W (ROW_W),
      .REG_W (REG_W),
      .NQ    (GRP),
      .BLK_W (BLK_W)
    ) bank_i (
      .clk      (clk),
      .wr_row   (row),
      .wr_qmask (wr_qmask),
      .wr_blk   (ld_data[k*BLK_W +: BLK_W]),
      .rd_row   (rd_idx[IDX_W-1:2]),
      .rd_word  (bank_rd[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_bank_q <= '0;
    else     rd_bank_q <= rd_idx[1:0];
  end

  assign rd_data = bank_rd[rd_bank_q];

  always_comb begin
    strb_d = '0;
    for (int r = 0; r < int'(NUM_REGS); r++) begin
      if (accept && (r / int'(GRP)) == int'(row)) strb_d[r*GRP +: GRP] = qmask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_strb <= '0;
      err     <= 1'b0;
    end else begin
      wr_strb <= strb_d;
      err     <= reject;
    end
  end

endmodule

// File: rtl/lsw_scatter_chk.sv
module lsw_scatter_chk #(
  parameter int unsigned NUM_REGS = 48,
  parameter int unsigned REG_W    = 256,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ld_valid,
  input logic                 ld_we,
  input logic [IDX_W-1:0]     ld_base,
  input logic [1:0]           ld_qsel,
  input logic [NUM_REGS*4-1:0] wr_strb,
  input logic                 err
);

  logic good_req;
  logic bad_req;
  assign good_req = ld_valid && ld_we && (ld_base[1:0] == 2'b00) &&
                    (int'(ld_base) <= int'(NUM_REGS) - 4);
  assign bad_req  = ld_valid && ld_we && !good_req;

  // R6
  accept_strb_chk: assert property (@(posedge clk) disable iff (rst)
    good_req |=> ($countones(wr_strb) == 4) && !err);

  // R5
  reject_err_chk: assert property (@(posedge clk) disable iff (rst)
    bad_req |=> err && (wr_strb == '0));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(ld_valid && ld_we) |=> !err && (wr_strb == '0));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !err && (wr_strb == '0));

  for (genvar r = 0; r < int'(NUM_REGS); r++) begin : g_reg
    // R3
    quarter_sel_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_strb[r*4 +: 4] != 4'b0) |-> (wr_strb[r*4 +: 4] == (4'b1 << $past(ld_qsel))));
    // R1
    group_hit_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_strb[r*4 +: 4] != 4'b0) |-> (int'($past(ld_base)) / 4 == r / 4));
  end

endmodule

bind lsw_scatter_writer lsw_scatter_chk #(
  .NUM_REGS (NUM_REGS),
  .REG_W    (REG_W),
  .IDX_W    (IDX_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .ld_valid (ld_valid),
  .ld_we    (ld_we),
  .ld_base  (ld_base),
  .ld_qsel  (ld_qsel),
  .wr_strb  (wr_strb),
  .err      (err)
);

// File: tb/lsw_scatter_writer_tb_top.sv
`timescale 1ns/1ps
module lsw_scatter_writer_tb_top;

  localparam int NR = 16;
  localparam int RW = 32;
  localparam int BW = RW / 4;
  localparam int IW = 4;
  localparam int SW = NR * 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_valid = 1'b0;
  logic          ld_we = 1'b0;
  logic [IW-1:0] ld_base = '0;
  logic [1:0]    ld_qsel = '0;
  logic [RW-1:0] ld_data = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [RW-1:0] rd_data;
  logic [SW-1:0] wr_strb;
  logic          err;

  int n_chk = 0;
  int n_fail = 0;
  logic [RW-1:0] model [NR];

  always #2 clk = ~clk;

  lsw_scatter_writer #(.NUM_REGS(NR), .REG_W(RW)) dut_i (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_we(ld_we),
    .ld_base(ld_base), .ld_qsel(ld_qsel), .ld_data(ld_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .wr_strb(wr_strb), .err(err)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] pat(input int a, input int b);
    return RW'((a * 32'h9E3779B1) ^ (b * 32'h85EBCA6B) ^ 32'h5A5A1234);
  endfunction

  // call at a negedge; returns at the next negedge with outputs checked
  task automatic issue(input int base, input int q, input logic [RW-1:0] d,
                       input bit v, input bit w);
    bit acc;
    logic [SW-1:0] es;
    acc = v && w && (base % 4 == 0) && (base <= NR - 4);
    es = '0;
    ld_valid = v; ld_we = w; ld_base = IW'(base); ld_qsel = 2'(q); ld_data = d;
    @(negedge clk);
    if (acc) begin
      for (int k = 0; k < 4; k++) begin
        es[(base + k) * 4 + q] = 1'b1;
        model[base + k][q*BW +: BW] = d[k*BW +: BW];
      end
      check("R6 strobe", 64'(wr_strb), 64'(es));
      check("R5 err low on accept", 64'(err), 64'(0));
    end else if (v && w) begin
      check("R5 strobe on reject", 64'(wr_strb), 64'(0));
      check("R5 err on reject", 64'(err), 64'(1));
    end else begin
      check("R7 strobe no request", 64'(wr_strb), 64'(0));
      check("R7 err no request", 64'(err), 64'(0));
    end
  endtask

  task automatic idle();
    ld_valid = 1'b0; ld_we = 1'b0;
  endtask

  task automatic read_all(input string tag);
    for (int r = 0; r < NR; r++) begin
      rd_idx = IW'(r);
      @(negedge clk);
      check(tag, 64'(rd_data), 64'(model[r]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [RW-1:0] old5;
    logic [RW-1:0] tile;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10
    check("R10 err after reset", 64'(err), 64'(0));
    check("R10 strobe after reset", 64'(wr_strb), 64'(0));

    // fill every group with four variants, then check tile layout (R4)
    for (int g = 0; g < NR; g += 4)
      for (int q = 0; q < 4; q++) issue(g, q, pat(g, q), 1, 1);
    idle();
    for (int g = 0; g < NR; g += 4)
      for (int k = 0; k < 4; k++) begin
        tile = '0;
        for (int q = 0; q < 4; q++) tile[q*BW +: BW] = pat(g, q)[k*BW +: BW];
        rd_idx = IW'(g + k);
        @(negedge clk);
        check("R4 tile row", 64'(rd_data), 64'(tile));
      end
    read_all("R1 fill readback");

    // sweep every base, quarter and enable (R1 R2 R3 R5 R7)
    for (int b = 0; b < NR; b++)
      for (int q = 0; q < 4; q++)
        for (int w = 0; w < 2; w++) begin
          issue(b, q, pat(b + 100, q * 2 + w), 1, w[0]);
          idle();
          if (w == 1 && b % 4 == 0 && b <= NR - 4) read_all("R2 R3 after accept");
          else read_all("R5 R7 no change");
        end

    // valid low with enable high (R7)
    issue(0, 2, 32'hFFFF_FFFF, 0, 1);
    idle();
    read_all("R7 valid low");

    // back-to-back loads (R8)
    issue(8, 0, 32'h1122_3344, 1, 1);
    issue(4, 3, 32'h5566_7788, 1, 1);
    issue(8, 0, 32'h99AA_BBCC, 1, 1);
    issue(12, 1, 32'hDDEE_F001, 1, 1);
    idle();
    read_all("R8 back to back");

    // read colliding with write at the same edge (R9)
    old5 = model[5];
    rd_idx = IW'(5);
    issue(4, 1, 32'hA5C3_0F96, 1, 1);
    idle();
    check("R9 same-edge read old", 64'(rd_data), 64'(old5));
    @(negedge clk);
    check("R9 next read new", 64'(rd_data), 64'(model[5]));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule